// File: doc/BRIEF.md
# Multiplexed LCD Scan Timing Generator

This block produces the digital timing for a multiplexed liquid-crystal panel with up to 16 common lines and 64 segment lines. It steps through the active commons in ascending order at a fixed step rate. For each common it presents a one-hot common select, the on/off pattern for every segment, and a polarity bit. The polarity bit flips once per frame so that the analogue drivers further down can average the cell voltage to zero. Analogue bias, the regulator and the level shifters sit outside this block.

Segment patterns come from a display RAM with a synchronous read port and one cycle of latency. The block always puts the row address of the *next* common on the read port, so the pattern is ready when the step arrives. Since the step rate is fixed, a smaller duty gives a shorter frame. At the default clocking, one step is the 1024 Hz tick, so frames run at 64 Hz with 16 commons and at 1024 Hz with one. A display mode input selects normal display, all segments lit, all segments dark, or power-down. Mode and duty changes are applied only at a frame boundary. A 4-bit contrast code is registered and passed on to the analogue side.

Top module: `lcd_scan_top`

## Requirements
- R1: While reset is asserted, `comSel`, `segOut`, `polarity`, `ramAddr` and `contrastOut` are all zero.
- R2: Outside power-down, `comSel` is one-hot and the commons are visited in the order 0, 1, ..., N-1, then 0 again, where N = 2^`dutySel` (codes 0 to 4 give 1, 2, 4, 8 and 16 commons).
- R3: Each common stays selected for exactly STEP_CYCLES clocks, so a frame lasts N × STEP_CYCLES clocks.
- R4: In normal mode (`dispMode` = 0), `segOut` equals the RAM row whose index is the selected common. `ramAddr` shows the index of the common that follows the current one (0 after the last, and 0 in power-down).
- R5: In all-on mode (`dispMode` = 1), every bit of `segOut` is 1 whatever the RAM holds, and scanning continues.
- R6: In all-off mode (`dispMode` = 2), every bit of `segOut` is 0 whatever the RAM holds, and scanning continues.
- R7: In power-down (`dispMode` = 3), `comSel`, `segOut` and `polarity` are zero and the scan is held at common 0. One clock after a non-power-down code is applied, scanning restarts at common 0 with a full step.
- R8: `polarity` flips at every frame boundary, and at no other time except when it is cleared on entering power-down.
- R9: A change on `dutySel` or `dispMode` has no effect until the next frame boundary. The frame in progress finishes with its old duty and mode, and the new values apply from common 0 onward.
- R10: `contrastOut` equals the `contrastIn` value sampled at the previous clock edge.
- R11: Duty codes 5 to 7 behave exactly like code 4 (16 commons).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dutySel | input | 3 | Duty code; the number of commons is 2^code, and codes above 4 are limited to 4 |
| dispMode | input | 2 | 0 normal, 1 all on, 2 all off, 3 power-down |
| contrastIn | input | 4 | Contrast code |
| ramRdData | input | 64 | Display RAM read data, valid one clock after the address |
| ramAddr | output | 4 | Display RAM row address (next common) |
| comSel | output | 16 | One-hot common select |
| segOut | output | 64 | Segment on/off vector for the selected common |
| polarity | output | 1 | Frame inversion bit |
| contrastOut | output | 4 | Registered contrast code |

## Verification
The hard case is a new duty or mode value arriving in the same cycle as the frame-boundary step. On that edge the wrap to common 0, the polarity flip, the row load and the capture of the new settings all happen together. The bench creates this case on purpose by changing the mode on the last clock of a frame. Random changes on other cycles hit the same edge by chance, and mid-frame changes test the hold rule. Every cycle is compared against a bench model built from the requirements: the common select, the segment vector, the polarity and the RAM address must all match.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL     = 2'd0,
    MODE_ALL_ON     = 2'd1,
    MODE_ALL_OFF    = 2'd2,
    MODE_POWER_DOWN = 2'd3
  } dispMode_e;

  // Strobes from the scan control to the segment/common datapath.
  typedef struct packed {
    logic scanOn;     // commons are being driven
    logic loadRow;    // capture RAM read data into the row register
    logic frameWrap;  // this step closes the frame
    logic segAllOn;   // force every segment on
    logic segAllOff;  // force every segment off
  } scanStb_t;

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM     = 16,
  parameter int STEP_CYCLES = 8,
  parameter int COM_W       = $clog2(NUM_COM),
  parameter int DUTY_W      = $clog2(COM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] dutySel,
  input  logic [1:0]        dispMode,
  output logic [COM_W-1:0]  ramAddr,
  output logic [COM_W-1:0]  comIdx,
  output logic              polarity,
  output logic [DUTY_W-1:0] dutyAct,
  output dispMode_e         modeAct,
  output scanStb_t          stb
);

  localparam int PRE_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(STEP_CYCLES - 1);
  localparam logic [DUTY_W-1:0] DUTY_MAX = DUTY_W'(COM_W);

  logic [PRE_W-1:0]  preCnt;
  logic [DUTY_W-1:0] dutyEff;
  logic [COM_W:0]    comCount;
  logic [COM_W-1:0]  lastIdx;
  logic [COM_W-1:0]  nextIdx;
  logic              running;
  logic              stepTick;
  logic              atLast;
  logic              wrap;

  always_comb begin
    running  = (modeAct != MODE_POWER_DOWN);
    dutyEff  = (dutyAct > DUTY_MAX) ? DUTY_MAX : dutyAct;
    comCount = {{COM_W{1'b0}}, 1'b1} << dutyEff;
    lastIdx  = COM_W'(comCount - 1'b1);
    stepTick = running && (preCnt == PRE_LAST);
    atLast   = (comIdx == lastIdx);
    wrap     = stepTick && atLast;
    nextIdx  = atLast ? '0 : comIdx + 1'b1;
    ramAddr  = running ? nextIdx : '0;

    stb.scanOn    = running;
    stb.loadRow   = stepTick || !running;
    stb.frameWrap = wrap;
    stb.segAllOn  = (modeAct == MODE_ALL_ON);
    stb.segAllOff = (modeAct == MODE_ALL_OFF) || !running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt   <= '0;
      comIdx   <= '0;
      polarity <= 1'b0;
      dutyAct  <= '0;
      modeAct  <= MODE_POWER_DOWN;
    end else if (!running) begin
      // Scan held at common 0; settings follow the inputs directly.
      preCnt   <= '0;
      comIdx   <= '0;
      polarity <= 1'b0;
      dutyAct  <= dutySel;
      modeAct  <= dispMode_e'(dispMode);
    end else begin
      preCnt <= stepTick ? '0 : preCnt + 1'b1;
      if (stepTick) begin
        comIdx <= nextIdx;
      end
      if (wrap) begin
        polarity <= (dispMode_e'(dispMode) == MODE_POWER_DOWN) ? 1'b0 : ~polarity;
        dutyAct  <= dutySel;
        modeAct  <= dispMode_e'(dispMode);
      end
    end
  end

endmodule

// File: rtl/lcd_scan_datapath.sv
module lcd_scan_datapath
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 64,
  parameter int COM_W   = $clog2(NUM_COM),
  parameter int CTR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  scanStb_t           stb,
  input  logic [COM_W-1:0]   comIdx,
  input  logic [NUM_SEG-1:0] ramRdData,
  input  logic [CTR_W-1:0]   contrastIn,
  output logic [NUM_COM-1:0] comSel,
  output logic [NUM_SEG-1:0] segOut,
  output logic [CTR_W-1:0]   contrastOut
);

  logic [NUM_SEG-1:0] rowReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowReg      <= '0;
      contrastOut <= '0;
    end else begin
      contrastOut <= contrastIn;
      if (stb.loadRow) begin
        rowReg <= ramRdData;
      end
    end
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : gComDec
    assign comSel[c] = stb.scanOn && (comIdx == COM_W'(c));
  end

  always_comb begin
    if (stb.segAllOn) begin
      segOut = '1;
    end else if (stb.segAllOff) begin
      segOut = '0;
    end else begin
      segOut = rowReg;
    end
  end

endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM     = 16,
  parameter int NUM_SEG     = 64,
  parameter int STEP_CYCLES = 8,
  parameter int CTR_W       = 4,
  localparam int COM_W      = $clog2(NUM_COM),
  localparam int DUTY_W     = $clog2(COM_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DUTY_W-1:0]  dutySel,
  input  logic [1:0]         dispMode,
  input  logic [CTR_W-1:0]   contrastIn,
  input  logic [NUM_SEG-1:0] ramRdData,
  output logic [COM_W-1:0]   ramAddr,
  output logic [NUM_COM-1:0] comSel,
  output logic [NUM_SEG-1:0] segOut,
  output logic               polarity,
  output logic [CTR_W-1:0]   contrastOut
);

  scanStb_t          scanStb;
  logic [COM_W-1:0]  comIdx;
  logic [DUTY_W-1:0] dutyAct;
  dispMode_e         modeAct;

  lcd_scan_ctrl #(
    .NUM_COM    (NUM_COM),
    .STEP_CYCLES(STEP_CYCLES),
    .COM_W      (COM_W),
    .DUTY_W     (DUTY_W)
  ) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .dutySel (dutySel),
    .dispMode(dispMode),
    .ramAddr (ramAddr),
    .comIdx  (comIdx),
    .polarity(polarity),
    .dutyAct (dutyAct),
    .modeAct (modeAct),
    .stb     (scanStb)
  );

  lcd_scan_datapath #(
    .NUM_COM(NUM_COM),
    .NUM_SEG(NUM_SEG),
    .COM_W  (COM_W),
    .CTR_W  (CTR_W)
  ) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (scanStb),
    .comIdx     (comIdx),
    .ramRdData  (ramRdData),
    .contrastIn (contrastIn),
    .comSel     (comSel),
    .segOut     (segOut),
    .contrastOut(contrastOut)
  );

endmodule

// File: rtl/lcd_scan_checker.sv
module lcd_scan_checker
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 64,
  parameter int DUTY_W  = 3,
  parameter int CTR_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CTR_W-1:0]   contrastIn,
  input logic [CTR_W-1:0]   contrastOut,
  input logic [NUM_COM-1:0] comSel,
  input logic [NUM_SEG-1:0] segOut,
  input logic               polarity,
  input scanStb_t           stb,
  input logic [DUTY_W-1:0]  dutyAct,
  input dispMode_e          modeAct
);

  logic pastValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  a_r2_onehot_com: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comSel));

  a_r3_step_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(stb.scanOn) && stb.scanOn && (comSel != $past(comSel)))
      |-> $past(stb.loadRow));

  a_r5_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (modeAct == MODE_ALL_ON) |-> ((&segOut) && (comSel != '0)));

  a_r6_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (modeAct == MODE_ALL_OFF) |-> ((segOut == '0) && (comSel != '0)));

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (modeAct == MODE_POWER_DOWN) |-> ((comSel == '0) && (segOut == '0) && !polarity));

  a_r8_pol_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && (polarity != $past(polarity))) |-> $past(stb.frameWrap));

  a_r9_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(stb.scanOn) && !$past(stb.frameWrap))
      |-> ($stable(dutyAct) && $stable(modeAct)));

  a_r10_contrast: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> (contrastOut == $past(contrastIn)));

endmodule

bind lcd_scan_top lcd_scan_checker #(
  .NUM_COM(NUM_COM),
  .NUM_SEG(NUM_SEG),
  .DUTY_W (DUTY_W),
  .CTR_W  (CTR_W)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .contrastIn (contrastIn),
  .contrastOut(contrastOut),
  .comSel     (comSel),
  .segOut     (segOut),
  .polarity   (polarity),
  .stb        (scanStb),
  .dutyAct    (dutyAct),
  .modeAct    (modeAct)
);

// File: tb/tb_lcd_scan_top.sv
module tb_lcd_scan_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCOM = 16;
  localparam int NSEG = 64;
  localparam int STEP = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      dutySel = 3'd0;
  logic [1:0]      dispMode = 2'd0;
  logic [3:0]      contrastIn = 4'd0;
  logic [NSEG-1:0] ramRdData = '0;
  logic [3:0]      ramAddr;
  logic [NCOM-1:0] comSel;
  logic [NSEG-1:0] segOut;
  logic            polarity;
  logic [3:0]      contrastOut;

  logic [NSEG-1:0] mem [NCOM];

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  // bench reference state
  int   mIdx, mPre, mMode, mDuty;
  logic mPol;

  always #5 clk = ~clk;

  lcd_scan_top #(.NUM_COM(NCOM), .NUM_SEG(NSEG), .STEP_CYCLES(STEP), .CTR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .dutySel(dutySel), .dispMode(dispMode),
    .contrastIn(contrastIn), .ramRdData(ramRdData), .ramAddr(ramAddr),
    .comSel(comSel), .segOut(segOut), .polarity(polarity), .contrastOut(contrastOut)
  );

  always_ff @(posedge clk) ramRdData <= mem[ramAddr];

  function automatic int nComs(int code);
    return 1 << ((code > 4) ? 4 : code);
  endfunction

  function automatic logic [NCOM-1:0] expCom();
    return (mMode == 3) ? '0 : (NCOM'(1) << mIdx);
  endfunction

  function automatic logic [NSEG-1:0] expSeg();
    case (mMode)
      0:       return mem[mIdx];
      1:       return '1;
      default: return '0;
    endcase
  endfunction

  function automatic int expAddr();
    if (mMode == 3) return 0;
    return (mIdx == nComs(mDuty) - 1) ? 0 : mIdx + 1;
  endfunction

  task automatic check(input string req, input logic [NSEG-1:0] act, input logic [NSEG-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    if (!rst_n) begin
      mIdx = 0; mPre = 0; mPol = 1'b0; mMode = 3; mDuty = 0;
    end else if (mMode == 3) begin
      mIdx = 0; mPre = 0; mPol = 1'b0; mDuty = dutySel; mMode = dispMode;
    end else if (mPre == STEP - 1) begin
      mPre = 0;
      if (mIdx == nComs(mDuty) - 1) begin
        mIdx  = 0;
        mPol  = (dispMode == 2'd3) ? 1'b0 : ~mPol;
        mDuty = dutySel;
        mMode = dispMode;
      end else begin
        mIdx++;
      end
    end else begin
      mPre++;
    end
  endtask

  // One clock: model follows the edge, outputs compared mid-cycle.
  task automatic cycle();
    string segTag;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    if (!rst_n) begin
      check("R1 comSel", NSEG'(comSel), '0);
      check("R1 segOut", segOut, '0);
      check("R1 polarity", NSEG'(polarity), '0);
      check("R1 ramAddr", NSEG'(ramAddr), '0);
      check("R1 contrastOut", NSEG'(contrastOut), '0);
    end else begin
      case (mMode)
        0: segTag = "R4 segOut";
        1: segTag = "R5 segOut";
        2: segTag = "R6 segOut";
        default: segTag = "R7 segOut";
      endcase
      check((mMode == 3) ? "R7 comSel" : "R2 comSel", NSEG'(comSel), NSEG'(expCom()));
      check(segTag, segOut, expSeg());
      check("R8 polarity", NSEG'(polarity), NSEG'(mPol));
      check("R4 ramAddr", NSEG'(ramAddr), NSEG'(expAddr()));
      check("R10 contrastOut", NSEG'(contrastOut), NSEG'(contrastIn));
    end
  endtask

  task automatic waitToggle(output int n);
    logic p0;
    p0 = polarity;
    n = 0;
    do begin
      cycle();
      n++;
    end while (polarity == p0 && n < 4000);
  endtask

  task automatic frameLen(input int code, input string req);
    int n;
    dutySel  = 3'(code);
    dispMode = 2'd0;
    waitToggle(n);
    waitToggle(n);
    check(req, NSEG'(n), NSEG'(nComs(code) * STEP));
  endtask

  task automatic waitCom(input int idx);
    int n = 0;
    while (comSel != (NCOM'(1) << idx) && n < 4000) begin
      cycle();
      n++;
    end
  endtask

  initial begin
    int n;
    int maxIdx;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NCOM; r++) mem[r] = {$urandom, $urandom};

    // R1: reset state
    rst_n = 1'b0;
    repeat (4) cycle();
    rst_n = 1'b1;

    // R3 / R2: frame length per duty, R11: clamped codes
    frameLen(4, "R3 frame len 1/16");
    frameLen(0, "R3 frame len 1/1");
    frameLen(1, "R3 frame len 1/2");
    frameLen(3, "R3 frame len 1/8");
    frameLen(6, "R11 frame len code6");
    frameLen(7, "R11 frame len code7");
    frameLen(2, "R3 frame len 1/4");

    // R9: mid-frame duty change finishes old frame
    waitCom(1);
    dutySel = 3'd3;
    maxIdx = 0;
    n = 0;
    begin
      logic p0;
      p0 = polarity;
      do begin
        cycle();
        n++;
        for (int c = 0; c < NCOM; c++) if (comSel[c] && c > maxIdx) maxIdx = c;
      end while (polarity == p0 && n < 4000);
    end
    check("R9 old duty completes (max common)", NSEG'(maxIdx), NSEG'(3));
    check("R9 new frame starts at common 0", NSEG'(comSel), NSEG'(1));
    waitToggle(n);
    check("R9 new duty frame len", NSEG'(n), NSEG'(8 * STEP));

    // Same-cycle case: mode change on the very last clock of a frame (R5, R9)
    waitCom(7);
    repeat (STEP - 1) cycle();
    dispMode = 2'd1;
    cycle();
    check("R5 all-on at boundary", segOut, '1);
    check("R9 wrap with new mode", NSEG'(comSel), NSEG'(1));
    repeat (3 * STEP) cycle();
    check("R5 scan continues", NSEG'(comSel != 0), NSEG'(1));

    // R6: all off
    dispMode = 2'd2;
    waitToggle(n);
    repeat (2 * STEP) cycle();
    check("R6 all-off", segOut, '0);

    // R7: power down, then exit
    dispMode = 2'd3;
    repeat (10 * STEP) cycle();
    check("R7 pd comSel", NSEG'(comSel), '0);
    check("R7 pd polarity", NSEG'(polarity), '0);
    dispMode = 2'd0;
    cycle();
    check("R7 restart common 0", NSEG'(comSel), NSEG'(1));
    check("R7 restart row 0", segOut, mem[0]);
    repeat (STEP - 1) cycle();
    check("R7 full first step", NSEG'(comSel), NSEG'(1));
    cycle();
    check("R7 then common 1", NSEG'(comSel), NSEG'(2));

    // Random phase
    for (int k = 0; k < 20000; k++) begin
      contrastIn = 4'($urandom);
      if ($urandom_range(0, 199) == 0) dutySel = 3'($urandom);
      if ($urandom_range(0, 249) == 0) begin
        n = $urandom_range(0, 9);
        dispMode = (n < 5) ? 2'd0 : (n < 7) ? 2'd1 : (n < 9) ? 2'd2 : 2'd3;
      end
      cycle();
    end

    // Mid-run reset (R1)
    rst_n = 1'b0;
    cycle();
    cycle();
    rst_n = 1'b1;
    repeat (4 * STEP) cycle();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule